// File: doc/BRIEF.md
# Line-Position Interrupt Unit

This block watches the raster position that a display timing generator presents and raises interrupts when the scan reaches chosen rows. It has four independent line-compare registers. Each one names a target row, and each sets its own pending bit when the scan arrives at the start (X = 0) of that row. The scan position arrives as an X/Y pair together with a qualifier that marks each new position. Every position is therefore seen once, however slowly the timing generator advances.

Software sees the pending bits raw through a status register. It acknowledges a pending bit by writing a one to that bit of a separate clear register. A mask register chooses which pending bits may drive the single level-high interrupt line. The register port is plain: a write strobe with an address and data, and an independent read address with a combinational read result. All registers are word-indexed:

| Index | Register | Contents |
|---|---|---|
| 0 to 3 | compare 0 to 3 | target row in bits 28:16 |
| 4 | status | pending bits 3:0 |
| 5 | clear | write-one-to-clear |
| 6 | mask | enables 3:0 |
| 7 | none | reads zero |

Top module: `lpi_unit`

## Requirements
- R1: After reset, every register reads zero and the interrupt line is low.
- R2: Each compare register (indices 0 to 3) keeps only the target row in bits 28:16. Every other bit reads back as zero.
- R3: Pending bit i (status bits 0 to 3 stand for compares 0 to 3) is set one clock after a qualified position with X = 0 and Y equal to compare register i.
- R4: A position with X not zero, an unqualified position, or a row that matches no compare register sets no pending bit.
- R5: Writing to the clear register (index 5) clears each pending bit whose data bit is one. Pending bits whose data bit is zero are left as they are.
- R6: When a match event and a clear of the same bit fall in the same clock, the bit ends up set.
- R7: The status register (index 4) shows the pending bits whatever the mask holds.
- R8: The interrupt line is high exactly when some pending bit has its mask bit (index 6, bits 3:0) set. It stays high until that pending bit is cleared or the mask bit is removed.
- R9: Writes to the status register and to index 7 change nothing. The clear register always reads zero.
- R10: Compare registers holding the same row set their pending bits together on one match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | clock |
| rst_ni | input | 1 | active-low synchronous reset |
| pos_valid_i | input | 1 | marks a new raster position this cycle |
| pos_x_i | input | 13 | raster column |
| pos_y_i | input | 13 | raster row |
| wr_en_i | input | 1 | register write strobe |
| wr_addr_i | input | 3 | register write index |
| wr_data_i | input | 32 | register write data |
| rd_addr_i | input | 3 | register read index |
| rd_data_o | output | 32 | register read data (combinational) |
| irq_o | output | 1 | level-high interrupt |

## Verification
Directed positions near each target separate a correct match from near misses. Column one on the target row, the right row without the qualifier, and an adjacent row must all leave the status untouched, while column zero on the target row must set exactly the matching bits. Two compares holding the same row show that matches are independent per line. A clear that lands in the same cycle as a match tells "set wins" apart from "clear wins". A long run of seeded random positions, clears and mask updates is compared cycle by cycle against a bench model. Because its rows are confined to a small range, matches, collisions and mask changes occur often.

// File: rtl/lpi_pkg.sv
package lpi_pkg;
  localparam int unsigned AW      = 3;
  localparam int unsigned ROW_LSB = 16;
  localparam int unsigned MAXLINE = 4;

  localparam logic [AW-1:0] IDX_STAT = 3'd4;
  localparam logic [AW-1:0] IDX_CLR  = 3'd5;
  localparam logic [AW-1:0] IDX_MASK = 3'd6;
endpackage

// File: rtl/lpi_regs.sv
module lpi_regs
  import lpi_pkg::*;
#(
  parameter int unsigned NLINE = 4,
  parameter int unsigned YW    = 13,
  parameter int unsigned DW    = 32
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic                       wr_en_i,
  input  logic [AW-1:0]              wr_addr_i,
  input  logic [DW-1:0]              wr_data_i,
  output logic [NLINE-1:0][YW-1:0]   row_o,
  output logic [NLINE-1:0]           mask_o,
  output logic [NLINE-1:0]           clr_o
);
  logic [NLINE-1:0][YW-1:0] row_q;
  logic [NLINE-1:0]         mask_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      row_q  <= '0;
      mask_q <= '0;
    end else if (wr_en_i) begin
      for (int i = 0; i < int'(NLINE); i++) begin
        if (wr_addr_i == AW'(i)) row_q[i] <= wr_data_i[ROW_LSB +: YW];
      end
      if (wr_addr_i == IDX_MASK) mask_q <= wr_data_i[NLINE-1:0];
    end
  end

  assign clr_o  = (wr_en_i && (wr_addr_i == IDX_CLR)) ? wr_data_i[NLINE-1:0] : '0;
  assign row_o  = row_q;
  assign mask_o = mask_q;
endmodule

// File: rtl/lpi_match.sv
module lpi_match #(
  parameter int unsigned NLINE = 4,
  parameter int unsigned XW    = 13,
  parameter int unsigned YW    = 13
) (
  input  logic                     pos_valid_i,
  input  logic [XW-1:0]            pos_x_i,
  input  logic [YW-1:0]            pos_y_i,
  input  logic [NLINE-1:0][YW-1:0] row_i,
  output logic [NLINE-1:0]         evt_o
);
  logic at_line_start;
  assign at_line_start = pos_valid_i && (pos_x_i == '0);

  for (genvar gi = 0; gi < NLINE; gi++) begin : g_cmp
    assign evt_o[gi] = at_line_start && (pos_y_i == row_i[gi]);
  end
endmodule

// File: rtl/lpi_pending.sv
module lpi_pending #(
  parameter int unsigned NLINE = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [NLINE-1:0] evt_i,
  input  logic [NLINE-1:0] clr_i,
  input  logic [NLINE-1:0] mask_i,
  output logic [NLINE-1:0] stat_o,
  output logic             irq_o
);
  logic [NLINE-1:0] stat_q;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) stat_q <= '0;
    else         stat_q <= (stat_q & ~clr_i) | evt_i;
  end

  assign stat_o = stat_q;
  assign irq_o  = |(stat_q & mask_i);
endmodule

// File: rtl/lpi_unit.sv
module lpi_unit
  import lpi_pkg::*;
#(
  parameter int unsigned NLINE = 4,
  parameter int unsigned XW    = 13,
  parameter int unsigned YW    = 13,
  parameter int unsigned DW    = 32
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          pos_valid_i,
  input  logic [XW-1:0] pos_x_i,
  input  logic [YW-1:0] pos_y_i,
  input  logic          wr_en_i,
  input  logic [2:0]    wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [2:0]    rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  output logic          irq_o
);
  logic [NLINE-1:0][YW-1:0] row_w;
  logic [NLINE-1:0]         mask_w;
  logic [NLINE-1:0]         clr_w;
  logic [NLINE-1:0]         evt_w;
  logic [NLINE-1:0]         stat_w;

  lpi_regs #(.NLINE(NLINE), .YW(YW), .DW(DW)) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i),
    .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .row_o(row_w), .mask_o(mask_w), .clr_o(clr_w)
  );

  lpi_match #(.NLINE(NLINE), .XW(XW), .YW(YW)) u_match (
    .pos_valid_i(pos_valid_i), .pos_x_i(pos_x_i), .pos_y_i(pos_y_i),
    .row_i(row_w), .evt_o(evt_w)
  );

  lpi_pending #(.NLINE(NLINE)) u_pend (
    .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_w), .clr_i(clr_w),
    .mask_i(mask_w), .stat_o(stat_w), .irq_o(irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < int'(NLINE); i++) begin
      if (rd_addr_i == AW'(i)) rd_data_o[ROW_LSB +: YW] = row_w[i];
    end
    if (rd_addr_i == IDX_STAT) rd_data_o[NLINE-1:0] = stat_w;
    if (rd_addr_i == IDX_MASK) rd_data_o[NLINE-1:0] = mask_w;
  end
endmodule

// File: rtl/lpi_unit_chk.sv
module lpi_unit_chk #(
  parameter int unsigned NLINE = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [NLINE-1:0] evt_i,
  input logic [NLINE-1:0] clr_i,
  input logic [NLINE-1:0] stat_i,
  input logic [NLINE-1:0] mask_i,
  input logic             irq_i
);
  for (genvar gi = 0; gi < NLINE; gi++) begin : g_bit
    // R3
    r3_match_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[gi] |=> stat_i[gi]);
    // R4
    r4_no_spurious_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!stat_i[gi] && !evt_i[gi]) |=> !stat_i[gi]);
    // R5
    r5_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[gi] && !evt_i[gi]) |=> !stat_i[gi]);
    // R6
    r6_set_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (clr_i[gi] && evt_i[gi]) |=> stat_i[gi]);
  end

  // R8
  r8_level_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && (clr_i == '0)) |=> (irq_i || !$stable(mask_i)));
endmodule

bind lpi_unit lpi_unit_chk #(.NLINE(NLINE)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .evt_i(evt_w), .clr_i(clr_w),
  .stat_i(stat_w), .mask_i(mask_w), .irq_i(irq_o)
);

// File: tb/test_lpi_unit.sv
module test_lpi_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        pv = 1'b0;
  logic [12:0] px = '0;
  logic [12:0] py = '0;
  logic        we = 1'b0;
  logic [2:0]  wa = '0;
  logic [31:0] wd = '0;
  logic [2:0]  ra = 3'd4;
  logic [31:0] rd;
  logic        irq;

  int checks = 0;
  int errors = 0;

  logic [12:0] m_row [4];
  logic [3:0]  m_mask;
  logic [3:0]  m_stat;

  always #2 clk = ~clk;

  lpi_unit i_lpi_unit (
    .clk_i(clk), .rst_ni(rst_n), .pos_valid_i(pv), .pos_x_i(px), .pos_y_i(py),
    .wr_en_i(we), .wr_addr_i(wa), .wr_data_i(wd), .rd_addr_i(ra),
    .rd_data_o(rd), .irq_o(irq)
  );

  function automatic logic [31:0] exp_read(input logic [2:0] a);
    logic [31:0] v = '0;
    if (a < 3'd4) v[28:16] = m_row[a[1:0]];
    else if (a == 3'd4) v[3:0] = m_stat;
    else if (a == 3'd6) v[3:0] = m_mask;
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic chk_read(input logic [2:0] a, input string req);
    ra = a;
    #0.5;
    chk(rd == exp_read(a), req, rd, exp_read(a));
    ra = 3'd4;
  endtask

  task automatic tick(input string req);
    logic [3:0] evt;
    logic [3:0] clr;
    @(posedge clk);
    for (int i = 0; i < 4; i++) evt[i] = pv && (px == 13'd0) && (py == m_row[i]);
    clr = (we && wa == 3'd5) ? wd[3:0] : 4'd0;
    if (we && wa < 3'd4) m_row[wa[1:0]] = wd[28:16];
    if (we && wa == 3'd6) m_mask = wd[3:0];
    m_stat = (m_stat & ~clr) | evt;
    #1;
    pv = 1'b0; we = 1'b0; ra = 3'd4;
    #0.5;
    chk(rd[3:0] == m_stat && rd[31:4] == '0, req, rd, {28'd0, m_stat});
    chk(irq == |(m_stat & m_mask), req, {31'd0, irq}, {31'd0, |(m_stat & m_mask)});
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d, input string req);
    we = 1'b1; wa = a; wd = d;
    tick(req);
  endtask

  task automatic pos(input logic v, input logic [12:0] x, input logic [12:0] y, input string req);
    pv = v; px = x; py = y;
    tick(req);
  endtask

  bit finished = 1'b0;

  initial begin
    #(200000 * 4);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 4; i++) m_row[i] = '0;
    m_mask = '0; m_stat = '0;
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    #0.5;
    // R1: every register reads zero, interrupt low
    for (int a = 0; a < 8; a++) chk_read(3'(a), "R1");
    chk(irq == 1'b0, "R1", {31'd0, irq}, 32'd0);

    // R2: only bits 28:16 are kept
    wr(3'd0, 32'hFFFF_FFFF, "R2");
    chk_read(3'd0, "R2");
    chk(exp_read(3'd0) == 32'h1FFF_0000, "R2", exp_read(3'd0), 32'h1FFF_0000);
    wr(3'd0, 32'd10 << 16, "R2");
    wr(3'd1, 32'd20 << 16, "R2");
    wr(3'd2, 32'd20 << 16, "R10");
    wr(3'd3, 32'h0000_FFFF | (32'd5 << 16), "R2");
    for (int a = 0; a < 4; a++) chk_read(3'(a), "R2");

    // R4: near misses set nothing
    pos(1'b1, 13'd1, 13'd10, "R4");
    pos(1'b0, 13'd0, 13'd10, "R4");
    pos(1'b1, 13'd0, 13'd11, "R4");
    chk(rd[3:0] == 4'd0, "R4", rd, 32'd0);

    // R3 and R7: match sets bit 0, raw status visible with mask clear
    pos(1'b1, 13'd0, 13'd10, "R3");
    chk(rd[3:0] == 4'b0001, "R3", rd, 32'd1);
    chk(irq == 1'b0, "R7", {31'd0, irq}, 32'd0);

    // R10: two compares on the same row
    pos(1'b1, 13'd0, 13'd20, "R10");
    chk(rd[3:0] == 4'b0111, "R10", rd, 32'd7);

    // R9: status write ignored, index 7 write ignored, clear reads zero
    wr(3'd4, 32'd0, "R9");
    wr(3'd7, 32'hFFFF_FFFF, "R9");
    chk(rd[3:0] == 4'b0111, "R9", rd, 32'd7);
    for (int a = 0; a < 8; a++) chk_read(3'(a), "R9");

    // R8: level held until acknowledged
    wr(3'd6, 32'd1, "R8");
    chk(irq == 1'b1, "R8", {31'd0, irq}, 32'd1);
    repeat (5) tick("R8");
    chk(irq == 1'b1, "R8", {31'd0, irq}, 32'd1);
    wr(3'd5, 32'b0010, "R5");
    chk(rd[3:0] == 4'b0101, "R5", rd, 32'd5);
    chk(irq == 1'b1, "R8", {31'd0, irq}, 32'd1);
    wr(3'd5, 32'b0001, "R8");
    chk(irq == 1'b0, "R8", {31'd0, irq}, 32'd0);

    // R6: clear and match of the same bit in one cycle
    pv = 1'b1; px = 13'd0; py = 13'd20;
    wr(3'd5, 32'b0100, "R6");
    chk(rd[3:0] == 4'b0110, "R6", rd, 32'd6);

    // R5: clear all
    wr(3'd5, 32'hF, "R5");
    chk(rd[3:0] == 4'd0, "R5", rd, 32'd0);

    // Random mix, checked each cycle against the model (R3 R5 R6 R8)
    for (int n = 0; n < 4000; n++) begin
      int r;
      r = int'($urandom_range(0, 99));
      pv = ($urandom_range(0, 3) != 0);
      px = ($urandom_range(0, 2) == 0) ? 13'($urandom_range(1, 8191)) : 13'd0;
      py = 13'($urandom_range(0, 7));
      if (r < 25) begin
        we = 1'b1; wa = 3'd5; wd = 32'($urandom_range(0, 15));
      end else if (r < 30) begin
        we = 1'b1; wa = 3'd6; wd = 32'($urandom_range(0, 15));
      end else if (r < 34) begin
        we = 1'b1; wa = 3'($urandom_range(0, 3)); wd = 32'($urandom_range(0, 7)) << 16;
      end
      tick("R3");
    end

    finished = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule